// File: doc/BRIEF.md
# Reduced 4x4 Inverse DCT

This block turns one 8x8 block of signed 16-bit quantized transform coefficients into a 4x4 block of 8-bit unsigned pixels. It does this with a two-pass fixed-point inverse transform that reads only part of the input. The coefficient block and the matching 8x8 quantization table are written into internal registers one word per cycle. A start pulse then runs the job. The first pass dequantizes each of the eight columns and reduces it to four intermediate values. The second pass reduces each of the four intermediate rows to four pixels. The sixteen pixels then stream out in raster order, one per cycle.

All arithmetic runs on a single time-shared multiply-accumulate unit. For each column group of four columns (0-3 and 4-7), a detector checks whether the raw AC coefficients that take part in the transform are all zero. If they are, that group takes a one-cycle-per-column DC path, and the block reports how many cycles this saved.

Top module: `idct4_reduced`

## Requirements
- R1: After reset, busy, pix_valid and done are low and saved_cycles is 0.
- R2: Pass 1 dequantizes each coefficient as the low 16 bits (two's complement) of the signed product of the coefficient and its table entry. Wrap-around is kept, not saturated.
- R3: Pass 1, for each column with dequantized values x0..x7, computes the following:
  - e0 = x0·2^14 and e2 = 15137·x2 − 6270·x6.
  - p = 8697·x1 − 17799·x3 + 11893·x5 − 1730·x7.
  - q = 20995·x1 + 7373·x3 − 4926·x5 − 4176·x7.
  - The four values are (e0+e2)+q, (e0−e2)+p, (e0−e2)−p and (e0+e2)−q, each taken modulo 2^32. Each is rounded by adding 2048, shifted right by 12 (arithmetic), and kept as its low 16 bits.
- R4: Pass 2 applies the R3 formulas, without dequantization, to intermediate row r (entries w0..w7). Each 32-bit result gives pixel (r, j) for j = 0..3, in the same order as R3, as clamp(((upper 16 bits) + 4) >> 3 arithmetic + 128) to 0..255.
- R5: A column group (columns 0-3 or 4-7) whose raw coefficients in rows 1, 2, 3, 5, 6 and 7 are all zero takes the DC path. This holds whatever the quantization values are. The DC path gives exactly the pixels that the full computation would give.
- R6: Coefficient row 4 and its table entries affect neither the pixels nor the DC-path decision.
- R7: On an accepted start, saved_cycles is set to 40 for each column group on the DC path (0, 40 or 80). It holds that value until the next accepted start.
- R8: The second pass begins only after all eight columns of pass 1 are complete. done is high exactly 147 − saved_cycles rising clock edges after the edge that samples start.
- R9: The pixels leave as exactly 16 consecutive pix_valid cycles in raster order: row 0 columns 0..3 first, then rows 1, 2 and 3. done is high together with the 16th pixel, and busy falls on the next edge.
- R10: A start pulse while busy is high is ignored. The running job and its timing are unchanged, and no second job follows.
- R11: Table and coefficient words are addressed as row·8 + column (address bits [5:3] are the row, bits [2:0] are the column).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Write strobe for one coefficient word |
| coef_addr | input | 6 | Coefficient address, row·8 + column |
| coef_data | input | 16 | Signed quantized coefficient |
| qt_we | input | 1 | Write strobe for one quantization word |
| qt_addr | input | 6 | Table address, row·8 + column |
| qt_data | input | 16 | Signed quantization multiplier |
| start | input | 1 | Begins a job when the block is idle |
| busy | output | 1 | High from the edge after an accepted start until the job ends |
| pix_valid | output | 1 | pix_data carries a pixel this cycle |
| pix_data | output | 8 | Unsigned output pixel |
| done | output | 1 | High with the last pixel of a job |
| saved_cycles | output | 7 | Cycles skipped by the DC path in the current job |

## Verification
Each pixel, done and the latency are due a fixed number of edges after start: 147 edges for a job with no shortcut, and 40 fewer for each group on the DC path. The bench counts rising edges from the one that samples start and reads every output at the following falling edge. It expects done at exactly that count and captures pixels at falling edges while pix_valid is high. saved_cycles is compared after done has been seen, and again some cycles later, to show that it holds. For the ignored start, the bench keeps watching for 200 cycles after done, so that any extra pixel burst would be caught.

// File: rtl/idct4_pkg.sv
package idct4_pkg;
  localparam int BLK        = 8;            // input block edge
  localparam int OUTN       = 4;            // output block edge
  localparam int GRP        = 4;            // columns per shortcut group
  localparam int NGRP       = BLK / GRP;
  localparam int GSH        = $clog2(GRP);
  localparam int CW         = 16;           // coefficient / sample width
  localparam int AW         = 32;           // accumulator width
  localparam int PW         = 8;            // pixel width
  localparam int STEPS      = 11;           // 10 MAC steps + 1 write step
  localparam int SAVE_GRP   = (STEPS - 1) * GRP;
  localparam logic [3:0] LAST_STEP = 4'(STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_P1, S_P2, S_OUT} phase_t;

  // which of the eight inputs feeds a MAC step
  function automatic logic [2:0] step_src(input logic [3:0] s);
    case (s)
      4'd0:       step_src = 3'd2;
      4'd1:       step_src = 3'd6;
      4'd2, 4'd6: step_src = 3'd7;
      4'd3, 4'd7: step_src = 3'd5;
      4'd4, 4'd8: step_src = 3'd3;
      default:    step_src = 3'd1;
    endcase
  endfunction

  // Q13 weight of a MAC step
  function automatic logic signed [CW-1:0] step_k(input logic [3:0] s);
    case (s)
      4'd0: step_k =  16'sd15137;
      4'd1: step_k = -16'sd6270;
      4'd2: step_k = -16'sd1730;
      4'd3: step_k =  16'sd11893;
      4'd4: step_k = -16'sd17799;
      4'd5: step_k =  16'sd8697;
      4'd6: step_k = -16'sd4176;
      4'd7: step_k = -16'sd4926;
      4'd8: step_k =  16'sd7373;
      4'd9: step_k =  16'sd20995;
      default: step_k = 16'sd0;
    endcase
  endfunction

  // a new sum starts at these steps
  function automatic logic step_clr(input logic [3:0] s);
    step_clr = (s == 4'd0) || (s == 4'd2) || (s == 4'd6);
  endfunction

  function automatic logic signed [CW-1:0] dequant(input logic signed [CW-1:0] c,
                                                   input logic signed [CW-1:0] q);
    logic signed [AW-1:0] m;
    m = AW'(c) * AW'(q);
    dequant = m[CW-1:0];
  endfunction

  // round by 2^12, keep low 16 bits
  function automatic logic signed [CW-1:0] narrow1(input logic signed [AW-1:0] v);
    logic signed [AW:0] t;
    t = $signed({v[AW-1], v}) + 33'sd2048;
    narrow1 = t[27:12];
  endfunction

  // upper half, round by 2^3, recentre, clamp
  function automatic logic [PW-1:0] to_pixel(input logic signed [AW-1:0] v);
    logic signed [16:0] r;
    logic signed [16:0] s;
    r = ($signed({v[AW-1], v[AW-1:16]}) + 17'sd4) >>> 3;
    s = r + 17'sd128;
    if (s[16])              to_pixel = 8'd0;
    else if (s > 17'sd255)  to_pixel = 8'd255;
    else                    to_pixel = s[PW-1:0];
  endfunction
endpackage

// File: rtl/idct4_mac.sv
module idct4_mac #(
  parameter int DW = 16,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [AW-1:0] acc
);
  logic signed [AW-1:0] prod;
  assign prod = AW'(a) * AW'(b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= clr ? prod : acc + prod;
  end
endmodule

// File: rtl/idct4_zero_detect.sv
module idct4_zero_detect
  import idct4_pkg::*;
(
  input  logic [BLK*BLK-1:0][CW-1:0] coefs,
  output logic [NGRP-1:0]            grp_zero
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [CW-1:0] orv;
    always_comb begin
      orv = '0;
      for (int r = 1; r < BLK; r++) begin
        if (r != BLK / 2) begin
          for (int c = g * GRP; c < (g + 1) * GRP; c++) orv |= coefs[r * BLK + c];
        end
      end
    end
    assign grp_zero[g] = (orv == '0);
  end
endmodule

// File: rtl/idct4_butterfly.sv
module idct4_butterfly
  import idct4_pkg::*;
(
  input  logic signed [CW-1:0]   x0,
  input  logic signed [AW-1:0]   e2,
  input  logic signed [AW-1:0]   p,
  input  logic signed [AW-1:0]   q,
  output logic [OUTN-1:0][AW-1:0] res
);
  logic signed [AW-1:0] e0, t10, t12;
  assign e0  = {{2{x0[CW-1]}}, x0, 14'b0};
  assign t10 = e0 + e2;
  assign t12 = e0 - e2;
  assign res[0] = t10 + q;
  assign res[1] = t12 + p;
  assign res[2] = t12 - p;
  assign res[3] = t10 - q;
endmodule

// File: rtl/idct4_reduced.sv
module idct4_reduced
  import idct4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       coef_we,
  input  logic [5:0] coef_addr,
  input  logic [15:0] coef_data,
  input  logic       qt_we,
  input  logic [5:0] qt_addr,
  input  logic [15:0] qt_data,
  input  logic       start,
  output logic       busy,
  output logic       pix_valid,
  output logic [7:0] pix_data,
  output logic       done,
  output logic [6:0] saved_cycles
);
  logic [BLK*BLK-1:0][CW-1:0]    coef_mem, qt_mem;
  logic [OUTN-1:0][BLK-1:0][CW-1:0] ws;          // [row][column]
  logic [OUTN-1:0][OUTN-1:0][PW-1:0] outbuf;     // [row][column]

  phase_t      phase;
  logic [2:0]  vec;
  logic [3:0]  step;
  logic [3:0]  opix;
  logic [NGRP-1:0] grp_sc, grp_now;
  logic signed [AW-1:0] acc, e2_r, p_r;
  logic [OUTN-1:0][AW-1:0] bf;
  logic [2:0]  src;
  logic signed [CW-1:0] sample, x0, dq0;
  logic        col_sc, mac_en;
  logic [6:0]  saved_now;

  // named internal events (observed by the checker)
  logic start_ok, p1_wr, sc_wr, p2_wr, p2_enter;

  // storage for the block and table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_mem <= '0;
      qt_mem   <= '0;
    end else begin
      if (coef_we) coef_mem[coef_addr] <= coef_data;
      if (qt_we)   qt_mem[qt_addr]     <= qt_data;
    end
  end

  idct4_zero_detect u_zd (.coefs(coef_mem), .grp_zero(grp_now));

  always_comb begin
    saved_now = '0;
    for (int g = 0; g < NGRP; g++) if (grp_now[g]) saved_now += 7'(SAVE_GRP);
  end

  // operand selection
  assign src    = step_src(step);
  assign col_sc = grp_sc[vec[2:GSH]];
  assign dq0    = dequant(coef_mem[{3'd0, vec}], qt_mem[{3'd0, vec}]);

  always_comb begin
    if (phase == S_P2) begin
      sample = ws[vec[1:0]][src];
      x0     = ws[vec[1:0]][0];
    end else begin
      sample = dequant(coef_mem[{src, vec}], qt_mem[{src, vec}]);
      x0     = dq0;
    end
  end

  assign mac_en = ((phase == S_P1 && !col_sc) || phase == S_P2) && (step != LAST_STEP);

  idct4_mac #(.DW(CW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .clr(step_clr(step)),
    .a(sample), .b(step_k(step)), .acc(acc)
  );

  idct4_butterfly u_bf (.x0(x0), .e2(e2_r), .p(p_r), .q(acc), .res(bf));

  assign start_ok = start && (phase == S_IDLE);
  assign sc_wr    = (phase == S_P1) && col_sc;
  assign p1_wr    = (phase == S_P1) && (col_sc || step == LAST_STEP);
  assign p2_wr    = (phase == S_P2) && (step == LAST_STEP);
  assign p2_enter = p1_wr && (vec == 3'(BLK - 1));

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase        <= S_IDLE;
      vec          <= '0;
      step         <= '0;
      opix         <= '0;
      grp_sc       <= '0;
      saved_cycles <= '0;
    end else begin
      case (phase)
        S_IDLE: if (start_ok) begin
          phase        <= S_P1;
          vec          <= '0;
          step         <= '0;
          grp_sc       <= grp_now;
          saved_cycles <= saved_now;
        end
        S_P1: if (p1_wr) begin
          step <= '0;
          vec  <= p2_enter ? 3'd0 : vec + 3'd1;
          if (p2_enter) phase <= S_P2;
        end else step <= step + 4'd1;
        S_P2: if (p2_wr) begin
          step <= '0;
          if (vec == 3'(OUTN - 1)) begin
            vec   <= '0;
            opix  <= '0;
            phase <= S_OUT;
          end else vec <= vec + 3'd1;
        end else step <= step + 4'd1;
        default: begin
          opix <= opix + 4'd1;
          if (opix == 4'hF) phase <= S_IDLE;
        end
      endcase
    end
  end

  // partial sums and result arrays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e2_r   <= '0;
      p_r    <= '0;
      ws     <= '0;
      outbuf <= '0;
    end else begin
      if (mac_en && step == 4'd2) e2_r <= acc;
      if (mac_en && step == 4'd6) p_r  <= acc;
      if (p1_wr) begin
        for (int k = 0; k < OUTN; k++)
          ws[k][vec] <= col_sc ? {dq0[CW-3:0], 2'b00} : narrow1(bf[k]);
      end
      if (p2_wr) begin
        for (int k = 0; k < OUTN; k++) outbuf[vec[1:0]][k] <= to_pixel(bf[k]);
      end
    end
  end

  assign busy      = (phase != S_IDLE);
  assign pix_valid = (phase == S_OUT);
  assign pix_data  = outbuf[opix[3:2]][opix[1:0]];
  assign done      = pix_valid && (opix == 4'hF);
endmodule

// File: rtl/idct4_checker.sv
module idct4_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       pix_valid,
  input logic       done,
  input logic [6:0] saved_cycles,
  input logic       p1_wr,
  input logic       sc_wr,
  input logic       p2_wr,
  input logic       p2_enter
);
  logic [3:0] p1_cnt, sc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_cnt <= '0;
      sc_cnt <= '0;
    end else if (start && !busy) begin
      p1_cnt <= '0;
      sc_cnt <= '0;
    end else begin
      if (p1_wr) p1_cnt <= p1_cnt + 4'd1;
      if (sc_wr) sc_cnt <= sc_cnt + 4'd1;
    end
  end

  assert_p2_after_p1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    p2_enter |-> (p1_cnt == 4'd7));
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_saved_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p2_enter |-> ((int'(sc_cnt) + int'(sc_wr)) * 10 == int'(saved_cycles)));
  assert_saved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(saved_cycles));
  assert_pix_in_job_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> busy);
  assert_done_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pix_valid);
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_no_pix_mid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_wr || p2_wr) |-> !pix_valid);
endmodule

bind idct4_reduced idct4_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .pix_valid(pix_valid),
  .done(done), .saved_cycles(saved_cycles), .p1_wr(p1_wr), .sc_wr(sc_wr),
  .p2_wr(p2_wr), .p2_enter(p2_enter)
);

// File: tb/idct4_reduced_test.sv
`timescale 1ns/1ps
module idct4_reduced_test;
  localparam real CLK_NS = 8.0;
  localparam int  FULL_LAT = 147;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coef_we = 0, qt_we = 0, start = 0;
  logic [5:0] coef_addr = '0, qt_addr = '0;
  logic [15:0] coef_data = '0, qt_data = '0;
  logic busy, pix_valid, done;
  logic [7:0] pix_data;
  logic [6:0] saved_cycles;

  always #(CLK_NS / 2) clk = ~clk;

  idct4_reduced uut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .qt_we(qt_we), .qt_addr(qt_addr), .qt_data(qt_data),
    .start(start), .busy(busy), .pix_valid(pix_valid), .pix_data(pix_data),
    .done(done), .saved_cycles(saved_cycles)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] seed;
    logic [6:0]  saved;
  } vec_t;

  // kind: 0 DC only, 1 AC only right, 2 AC only left, 3 full small, 4 full wrapping, 5 DC extremes
  localparam vec_t TBL [6] = '{
    '{3'd0, 16'h1357, 7'd80},
    '{3'd1, 16'h2468, 7'd40},
    '{3'd2, 16'h0bad, 7'd40},
    '{3'd3, 16'h7c01, 7'd0},
    '{3'd4, 16'h55aa, 7'd0},
    '{3'd5, 16'h0f0f, 7'd80}
  };

  int nchk = 0, nerr = 0;
  bit finished = 0;
  int cf [8][8];
  int qv [8][8];
  int expv [16];
  int got [16];
  int npix, lat;
  int lcg;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 16) & 32'h7fff;
  endfunction

  function automatic longint sx16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return longint'(t);
  endfunction

  function automatic longint sx32(input longint v);
    logic signed [31:0] t;
    t = v[31:0];
    return longint'(t);
  endfunction

  // four weighted outputs for one vector, exact in 64 bits
  task automatic vec4(input longint x [8], output longint o [4]);
    longint a, b, p, q;
    a = x[0] * 16384 + 15137 * x[2] - 6270 * x[6];
    b = x[0] * 16384 - 15137 * x[2] + 6270 * x[6];
    p = 8697 * x[1] - 17799 * x[3] + 11893 * x[5] - 1730 * x[7];
    q = 20995 * x[1] + 7373 * x[3] - 4926 * x[5] - 4176 * x[7];
    o[0] = a + q; o[1] = b + p; o[2] = b - p; o[3] = a - q;
  endtask

  task automatic model();
    longint x [8];
    longint o [4];
    longint mid [4][8];
    longint v;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) x[k] = sx16(longint'(cf[k][c]) * longint'(qv[k][c]));
      vec4(x, o);
      for (int k = 0; k < 4; k++) mid[k][c] = sx16((sx32(o[k]) + 2048) >>> 12);
    end
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 8; k++) x[k] = mid[r][k];
      vec4(x, o);
      for (int j = 0; j < 4; j++) begin
        v = (((sx32(o[j]) >>> 16) + 4) >>> 3) + 128;
        expv[r * 4 + j] = (v < 0) ? 0 : (v > 255) ? 255 : int'(v);
      end
    end
  endtask

  task automatic build(input int kind, input int seed);
    bit ac_on;
    lcg = seed;
    for (int c = 0; c < 8; c++) begin
      ac_on = (kind == 3) || (kind == 4) || (kind == 1 && c >= 4) || (kind == 2 && c < 4);
      for (int r = 0; r < 8; r++) begin
        qv[r][c] = (kind == 4) ? 1 + rnd() % 255 : 1 + rnd() % 16;
        if (r == 0) cf[r][c] = (kind == 4) ? rnd() % 4096 - 2048 : rnd() % 512 - 256;
        else if (r == 4) cf[r][c] = 100 + rnd() % 100;
        else if (!ac_on) cf[r][c] = 0;
        else cf[r][c] = (kind == 4) ? rnd() % 4096 - 2048 : rnd() % 64 - 32;
      end
      if (ac_on && cf[1][c] == 0) cf[1][c] = 3;
      if (kind == 5) begin
        cf[0][c] = (c < 4) ? 500 : -500;
        qv[0][c] = 16;
      end
    end
  endtask

  task automatic load();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      coef_we = 1; coef_addr = 6'(i); coef_data = 16'(cf[i / 8][i % 8]);
      qt_we = 1;   qt_addr = 6'(i);   qt_data = 16'(qv[i / 8][i % 8]);
    end
    @(negedge clk);
    coef_we = 0; qt_we = 0;
  endtask

  // run one job, capture pixels and latency
  task automatic run_job(input bit extra_start);
    @(negedge clk); start = 1;
    @(posedge clk);
    lat = 0; npix = 0;
    forever begin
      @(negedge clk);
      start = extra_start && (lat == 30);
      if (pix_valid) begin
        if (npix < 16) got[npix] = int'(pix_data);
        npix++;
      end
      if (done || lat > 400) break;
      @(posedge clk);
      lat++;
    end
    start = 0;
  endtask

  task automatic check_job(input string req, input int exp_saved);
    model();
    chk(npix == 16, "R9 pixel count", npix, 16);
    chk(lat == FULL_LAT - exp_saved, "R8 latency", lat, FULL_LAT - exp_saved);
    chk(int'(saved_cycles) == exp_saved, "R7 saved_cycles", saved_cycles, exp_saved);
    for (int i = 0; i < 16; i++)
      chk(got[i] == expv[i], {req, " pixel (raster order R9)"}, got[i], expv[i]);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int prev [16];
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !pix_valid && !done, "R1 idle outputs", {busy, pix_valid, done}, 0);
    chk(saved_cycles == 0, "R1 saved_cycles", saved_cycles, 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R2 wrap, R3 full, R4 final stage, R5 shortcut groups
    for (int t = 0; t < 6; t++) begin
      string tag;
      case (int'(TBL[t].kind))
        3: tag = "R3";
        4: tag = "R2";
        5: tag = "R4";
        default: tag = "R5";
      endcase
      build(int'(TBL[t].kind), int'(TBL[t].seed));
      load();
      run_job(0);
      check_job(tag, int'(TBL[t].saved));
      if (t == 3) for (int i = 0; i < 16; i++) prev[i] = got[i];
    end

    // R7: value holds after the job
    repeat (5) @(negedge clk);
    chk(int'(saved_cycles) == 80, "R7 hold after done", saved_cycles, 80);

    // R6: row 4 altered only, pixels equal to the earlier run
    build(3, 16'h7c01);
    for (int c = 0; c < 8; c++) begin
      cf[4][c] = -1000 - 37 * c;
      qv[4][c] = 200 + c;
    end
    load();
    run_job(0);
    for (int i = 0; i < 16; i++) chk(got[i] == prev[i], "R6 row 4 ignored", got[i], prev[i]);
    chk(int'(saved_cycles) == 0, "R6 saved_cycles", saved_cycles, 0);

    // R6/R5: only row 4 nonzero in AC rows gives full shortcut
    build(0, 16'h4242);
    load();
    run_job(0);
    check_job("R6", 80);

    // R11: a single AC term at row 1, column 5 (address 13)
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        cf[r][c] = (r == 0) ? 40 * c - 100 : 0;
        qv[r][c] = 3 + r + c;
      end
    cf[1][5] = 7;
    load();
    run_job(0);
    check_job("R11", 40);

    // R10: start while busy is ignored
    build(3, 16'h3c3c);
    load();
    run_job(1);
    check_job("R10", 0);
    npix = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pix_valid || busy) npix++;
    end
    chk(npix == 0, "R10 no second job", npix, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule